// File: doc/BRIEF.md
# Mode-Configurable Dual-Port RAM

This block is a 2,304-bit memory with one write port and one read port, each on its own clock. A 2-bit geometry input sets the array's aspect ratio at run time: 128 words of 18 bits, 256 of 9, 512 of 4 or 1024 of 2. Both ports always carry a 10-bit address and an 18-bit data bus. Address bits above the selected depth are ignored, and data bits above the selected width are ignored on writes and returned as zero on reads.

All geometries share one flat bit array. Word `w` of width `W` occupies bits `w*W` up to `w*W+W-1`, so data written under one geometry can be read back under another. Writes are synchronous to the write clock, and the write enable acts as that clock's enable. The read port has two modes, picked by a select input. In clocked mode the read enable gates a registered read on the read clock, and a disabled read holds the last word. In flow-through mode an asserted read enable makes the output follow the addressed word combinationally.

Top module: `cfg_dpram`

## Requirements
- R1: Geometry code 0 gives 128x18, code 1 gives 256x9, code 2 gives 512x4 and code 3 gives 1024x2. Address bits at and above log2(depth) have no effect on either port.
- R2: Word w of width W is stored in flat bits w*W to w*W+W-1, counted from bit 0 upward. For example, an 18-bit word written at address 0 under code 0 reads back under code 1 as its bits 8:0 at address 0 and its bits 17:9 at address 1.
- R3: Write data bits at and above the current width are not stored. Read data bits at and above the current width are zero.
- R4: While the write enable is low, a write-clock edge changes no stored bit.
- R5: With the async select low and read enable high, the word at the read address appears on the read data output after the next read-clock edge.
- R6: With the async select low and read enable low, the read data output holds its value across read-clock edges.
- R7: With the async select high and read enable high, the read data output follows the read address and stored contents with no clock edge needed.
- R8: With the async select high and read enable low, the output shows the held registered word and ignores the read address.
- R9: When a clocked read and a write hit the same word on a shared clock edge, the read returns the newly written data (write-through).
- R10: While the active-low read reset is low, the registered read word is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| wen | input | 1 | Write enable (clock enable on wclk) |
| waddr | input | 10 | Write address |
| wdata | input | 18 | Write data |
| rclk | input | 1 | Read clock |
| rrst_n | input | 1 | Active-low synchronous reset of the read register |
| ren | input | 1 | Read enable |
| async_rd | input | 1 | 1 = flow-through read, 0 = clocked read |
| mode | input | 2 | Geometry code |
| raddr | input | 10 | Read address |
| rdata | output | 18 | Read data |

## Verification
A wrong base-offset or lane-mask computation shows up right away as a word that overlaps its neighbour or leaks into the unused upper bits. It is visible on the first clocked read after the write, or within the same cycle in flow-through mode. A corrupt held read word is visible on the very next read-clock edge with the enable low. A missing write-through path returns the stale word one cycle after the colliding edge. Cross-geometry reads expose a packing error without needing any internal visibility.

// File: rtl/cfg_dpram_pkg.sv
package cfg_dpram_pkg;
    localparam int RAM_ADDR_W = 10;
    localparam int RAM_DATA_W = 18;
    localparam int RAM_BITS   = 2304;
    localparam int RAM_OFF_W  = $clog2(RAM_BITS);

    typedef enum logic [1:0] {
        GEOM_128X18  = 2'd0,
        GEOM_256X9   = 2'd1,
        GEOM_512X4   = 2'd2,
        GEOM_1024X2  = 2'd3
    } geom_e;

    // Word width for each geometry.
    function automatic int geom_width(geom_e g);
        case (g)
            GEOM_128X18: return 18;
            GEOM_256X9:  return 9;
            GEOM_512X4:  return 4;
            default:     return 2;
        endcase
    endfunction

    // Number of address bits that index a word.
    function automatic int geom_addr_bits(geom_e g);
        case (g)
            GEOM_128X18: return 7;
            GEOM_256X9:  return 8;
            GEOM_512X4:  return 9;
            default:     return 10;
        endcase
    endfunction
endpackage

// File: rtl/cfg_dpram_map.sv
module cfg_dpram_map
    import cfg_dpram_pkg::*;
#(
    parameter int ADDR_W = RAM_ADDR_W,
    parameter int DATA_W = RAM_DATA_W,
    parameter int OFF_W  = RAM_OFF_W
) (
    input  geom_e              geom,
    input  logic [ADDR_W-1:0]  addr,
    output logic [ADDR_W-1:0]  word_idx,
    output logic [OFF_W-1:0]   base,
    output logic [DATA_W-1:0]  lane_mask
);
    always_comb begin
        word_idx  = addr & ADDR_W'((1 << geom_addr_bits(geom)) - 1);
        base      = OFF_W'(word_idx) * OFF_W'(geom_width(geom));
        lane_mask = DATA_W'((1 << geom_width(geom)) - 1);
    end
endmodule

// File: rtl/cfg_dpram_store.sv
module cfg_dpram_store
    import cfg_dpram_pkg::*;
#(
    parameter int TOTAL_BITS = RAM_BITS,
    parameter int DATA_W     = RAM_DATA_W,
    parameter int OFF_W      = RAM_OFF_W
) (
    input  logic                  wclk,
    input  logic                  wen,
    input  logic [OFF_W-1:0]      base,
    input  logic [DATA_W-1:0]     lane_mask,
    input  logic [DATA_W-1:0]     wdata,
    output logic [TOTAL_BITS-1:0] bits
);
    typedef struct packed {
        logic [TOTAL_BITS-1:0] cells;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wen) begin
            for (int i = 0; i < DATA_W; i++) begin
                if (lane_mask[i]) begin
                    st_d.cells[base + OFF_W'(i)] = wdata[i];
                end
            end
        end
    end

    always_ff @(posedge wclk) begin
        st_q <= st_d;
    end

    assign bits = st_q.cells;
endmodule

// File: rtl/cfg_dpram_rport.sv
module cfg_dpram_rport
    import cfg_dpram_pkg::*;
#(
    parameter int TOTAL_BITS = RAM_BITS,
    parameter int DATA_W     = RAM_DATA_W,
    parameter int OFF_W      = RAM_OFF_W
) (
    input  logic                  rclk,
    input  logic                  rrst_n,
    input  logic                  ren,
    input  logic                  async_rd,
    input  logic [OFF_W-1:0]      base,
    input  logic [DATA_W-1:0]     lane_mask,
    input  logic [TOTAL_BITS-1:0] bits,
    input  logic                  fwd_hit,
    input  logic [DATA_W-1:0]     fwd_data,
    output logic [DATA_W-1:0]     rdata
);
    typedef struct packed {
        logic [DATA_W-1:0] word;
    } rd_t;

    rd_t st_d, st_q;
    logic [DATA_W-1:0] word_now;
    logic [DATA_W-1:0] word_fwd;

    // Current stored word, upper lanes forced to zero.
    always_comb begin
        word_now = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (lane_mask[i]) begin
                word_now[i] = bits[base + OFF_W'(i)];
            end
        end
        word_fwd = fwd_hit ? (fwd_data & lane_mask) : word_now;
    end

    always_comb begin
        st_d = st_q;
        if (!rrst_n) begin
            st_d.word = '0;
        end else if (ren && !async_rd) begin
            st_d.word = word_fwd;
        end
    end

    always_ff @(posedge rclk) begin
        st_q <= st_d;
    end

    assign rdata = (async_rd && ren) ? word_now : st_q.word;
endmodule

// File: rtl/cfg_dpram.sv
module cfg_dpram
    import cfg_dpram_pkg::*;
#(
    parameter int ADDR_W     = RAM_ADDR_W,
    parameter int DATA_W     = RAM_DATA_W,
    parameter int TOTAL_BITS = RAM_BITS
) (
    input  logic              wclk,
    input  logic              wen,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              ren,
    input  logic              async_rd,
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int OFF_W = $clog2(TOTAL_BITS);

    geom_e                 geom;
    logic [ADDR_W-1:0]     w_idx, r_idx;
    logic [OFF_W-1:0]      w_base, r_base;
    logic [DATA_W-1:0]     w_mask, r_mask;
    logic [TOTAL_BITS-1:0] cells;
    logic                  hit;

    assign geom = geom_e'(mode);

    cfg_dpram_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_wmap (
        .geom(geom), .addr(waddr), .word_idx(w_idx), .base(w_base), .lane_mask(w_mask)
    );

    cfg_dpram_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_rmap (
        .geom(geom), .addr(raddr), .word_idx(r_idx), .base(r_base), .lane_mask(r_mask)
    );

    cfg_dpram_store #(.TOTAL_BITS(TOTAL_BITS), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_store (
        .wclk(wclk), .wen(wen), .base(w_base), .lane_mask(w_mask),
        .wdata(wdata), .bits(cells)
    );

    // Same-word collision steers the new write data into the read register.
    assign hit = wen && (w_idx == r_idx);

    cfg_dpram_rport #(.TOTAL_BITS(TOTAL_BITS), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_rport (
        .rclk(rclk), .rrst_n(rrst_n), .ren(ren), .async_rd(async_rd),
        .base(r_base), .lane_mask(r_mask), .bits(cells),
        .fwd_hit(hit), .fwd_data(wdata), .rdata(rdata)
    );
endmodule

// File: rtl/cfg_dpram_chk.sv
module cfg_dpram_chk
    import cfg_dpram_pkg::*;
#(
    parameter int DATA_W = RAM_DATA_W
) (
    input logic              rclk,
    input logic              rrst_n,
    input logic              ren,
    input logic              async_rd,
    input logic [1:0]        mode,
    input logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] upper;

    always_comb begin
        upper = ~DATA_W'((1 << geom_width(geom_e'(mode))) - 1);
    end

    // R10: one edge of reset leaves a zero registered word.
    p_reset_clear_r10: assert property (@(posedge rclk)
        (!rrst_n) ##1 (!async_rd) |-> (rdata == '0));

    // R6: clocked mode with read enable low keeps the output.
    p_sync_hold_r6: assert property (@(posedge rclk) disable iff (!rrst_n)
        (!async_rd && !ren) ##1 (!async_rd) |-> $stable(rdata));

    // R3: flow-through word has zero upper lanes.
    p_async_upper_zero_r3: assert property (@(posedge rclk) disable iff (!rrst_n)
        (async_rd && ren) |-> ((rdata & upper) == '0));

    // R3: a freshly registered word has zero upper lanes.
    p_sync_upper_zero_r3: assert property (@(posedge rclk) disable iff (!rrst_n)
        (ren && !async_rd) ##1 (!async_rd && $stable(mode)) |-> ((rdata & upper) == '0));
endmodule

bind cfg_dpram cfg_dpram_chk u_chk (
    .rclk(rclk), .rrst_n(rrst_n), .ren(ren), .async_rd(async_rd),
    .mode(mode), .rdata(rdata)
);

// File: tb/sim_cfg_dpram.sv
`timescale 1ns/1ps
module sim_cfg_dpram;
    logic        clk = 1'b0;
    logic        wen = 1'b0, rrst_n = 1'b0, ren = 1'b0, async_rd = 1'b0;
    logic [9:0]  waddr = '0, raddr = '0;
    logic [17:0] wdata = '0;
    logic [1:0]  mode = '0;
    logic [17:0] rdata;
    logic [2303:0] model = '0;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cfg_dpram u0 (
        .wclk(clk), .wen(wen), .waddr(waddr), .wdata(wdata),
        .rclk(clk), .rrst_n(rrst_n), .ren(ren), .async_rd(async_rd),
        .mode(mode), .raddr(raddr), .rdata(rdata)
    );

    function automatic int wid(logic [1:0] m);
        case (m) 2'd0: return 18; 2'd1: return 9; 2'd2: return 4; default: return 2; endcase
    endfunction

    function automatic int abits(logic [1:0] m);
        case (m) 2'd0: return 7; 2'd1: return 8; 2'd2: return 9; default: return 10; endcase
    endfunction

    function automatic logic [17:0] model_read(logic [1:0] m, logic [9:0] a);
        logic [17:0] r = '0;
        int idx = int'(a) & ((1 << abits(m)) - 1);
        for (int i = 0; i < wid(m); i++) r[i] = model[idx * wid(m) + i];
        return r;
    endfunction

    task automatic model_write(logic [1:0] m, logic [9:0] a, logic [17:0] d);
        int idx = int'(a) & ((1 << abits(m)) - 1);
        for (int i = 0; i < wid(m); i++) model[idx * wid(m) + i] = d[i];
    endtask

    task automatic check(string tag, logic [17:0] act, logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(logic [1:0] m, logic [9:0] a, logic [17:0] d);
        @(negedge clk);
        mode = m; waddr = a; wdata = d; wen = 1'b1;
        @(negedge clk);
        wen = 1'b0;
        model_write(m, a, d);
    endtask

    task automatic do_sread(logic [1:0] m, logic [9:0] a, output logic [17:0] q);
        @(negedge clk);
        mode = m; raddr = a; async_rd = 1'b0; ren = 1'b1;
        @(negedge clk);
        ren = 1'b0;
        q = rdata;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R10 reset clears", rdata, 18'h0);
        rrst_n = 1'b1;
        @(negedge clk);
        check("R10 after release", rdata, 18'h0);
    endtask

    task automatic t_geometry();
        logic [17:0] q;
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 4; k++) begin
                logic [9:0] a = 10'((k * 37 + 3) & ((1 << abits(2'(m))) - 1));
                logic [9:0] alias_bits = 10'h3FF & ~10'((1 << abits(2'(m))) - 1);
                logic [17:0] d = 18'h15A5A ^ 18'(k * 18'h00137) ^ 18'(m);
                do_write(2'(m), a | alias_bits, d);
                do_sread(2'(m), a, q);
                check("R1 R5 geometry read", q, model_read(2'(m), a));
            end
        end
    endtask

    task automatic t_packing();
        logic [17:0] q;
        do_write(2'd0, 10'd0, 18'h2AB3C);
        do_sread(2'd1, 10'd0, q);
        check("R2 low half", q, 18'h0013C);
        do_sread(2'd1, 10'd1, q);
        check("R2 high half", q, 18'h00155);
        do_sread(2'd3, 10'd1, q);
        check("R2 pair 1", q, 18'h00003);
    endtask

    task automatic t_width();
        logic [17:0] q;
        do_write(2'd2, 10'd6, 18'h0000A);
        do_write(2'd2, 10'd5, 18'h3FFF5);
        do_sread(2'd2, 10'd5, q);
        check("R3 upper write bits dropped", q, 18'h00005);
        do_sread(2'd2, 10'd6, q);
        check("R3 neighbour intact", q, 18'h0000A);
    endtask

    task automatic t_wen();
        logic [17:0] q;
        do_write(2'd1, 10'd20, 18'h000AA);
        @(negedge clk);
        waddr = 10'd20; wdata = 18'h001FF; wen = 1'b0;
        @(negedge clk);
        do_sread(2'd1, 10'd20, q);
        check("R4 disabled write", q, 18'h000AA);
    endtask

    task automatic t_hold();
        logic [17:0] q;
        do_write(2'd1, 10'd30, 18'h00111);
        do_write(2'd1, 10'd31, 18'h000EE);
        do_sread(2'd1, 10'd30, q);
        check("R5 clocked read", q, 18'h00111);
        raddr = 10'd31;
        repeat (3) @(negedge clk);
        check("R6 hold with enable low", rdata, 18'h00111);
    endtask

    task automatic t_async();
        @(negedge clk);
        mode = 2'd1; async_rd = 1'b1; ren = 1'b1; raddr = 10'd30;
        #1 check("R7 flow-through a", rdata, 18'h00111);
        raddr = 10'd31;
        #1 check("R7 flow-through b", rdata, 18'h000EE);
        do_write(2'd1, 10'd31, 18'h00055);
        #1 check("R7 follows new contents", rdata, 18'h00055);
    endtask

    task automatic t_async_off();
        @(negedge clk);
        ren = 1'b0; raddr = 10'd30;
        #1 check("R8 held word shown", rdata, 18'h00111);
        raddr = 10'd31;
        repeat (2) @(negedge clk);
        check("R8 address ignored", rdata, 18'h00111);
        async_rd = 1'b0;
    endtask

    task automatic t_collision();
        do_write(2'd0, 10'd40, 18'h01234);
        @(negedge clk);
        mode = 2'd0; waddr = 10'd40; wdata = 18'h3CDEF; wen = 1'b1;
        raddr = 10'd40; ren = 1'b1; async_rd = 1'b0;
        @(negedge clk);
        wen = 1'b0; ren = 1'b0;
        model_write(2'd0, 10'd40, 18'h3CDEF);
        check("R9 write-through", rdata, 18'h3CDEF);
        @(negedge clk);
        mode = 2'd1; waddr = 10'h300 | 10'd50; wdata = 18'h3FF6B; wen = 1'b1;
        raddr = 10'd50; ren = 1'b1;
        @(negedge clk);
        wen = 1'b0; ren = 1'b0;
        model_write(2'd1, 10'd50, 18'h3FF6B);
        check("R9 aliased write-through masked", rdata, 18'h0016B);
    endtask

    initial begin
        t_reset();
        t_geometry();
        t_packing();
        t_width();
        t_wen();
        t_hold();
        t_async();
        t_async_off();
        t_collision();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule